// File: doc/BRIEF.md
# Mode-Switched Banked Address Composer

This block is pure combinational logic. It sits between a scanline-counting bank-switching core and the program and pattern ROMs of a cartridge. It builds the final 22-bit program ROM address and the 20-bit pattern ROM address. To do this it merges three sources: the bus addresses, the core's bank outputs, and the fields of an outer configuration byte. It also produces the CPU A13 and A14 values that the core receives. In the fixed program modes it forces both low, so that one core bank register covers the whole $8000-$FFFF window.

Two mode fields choose the program-side and pattern-side behaviour. The program side has a banked mode and two fixed-window modes: a 16 KiB mirrored window and a 32 KiB linear window. The pattern side has a banked mode and a fixed 8 KiB mode, in which a separate 4-bit bank number replaces the core's pattern bank outputs. Two bits of the outer byte each choose the inner bank size, 128 KiB or 256 KiB, for one side. The block holds no state, so it has no states and no transitions. The program mode decode is written as a single case over the four named modes: PM_BANKED, PM_HALF, PM_HALF_ALT and PM_FULL.

Top module: `mapcomp_top`

## Requirements
- R1: prg_addr[12:0] always equals cpu_addr[12:0] in every mode.
- R2: prg_addr[21:20] equals outer_cfg[5:4], and prg_addr[19:18] equals outer_cfg[2:1].
- R3: prg_addr[17] equals outer_cfg[0] when outer_cfg[6] is 1, and equals core_prg_bank[4] (the core's A17) when outer_cfg[6] is 0.
- R4: When prg_mode is 0, core_cpu_a13 and core_cpu_a14 equal cpu_addr[13] and cpu_addr[14]. When prg_mode is 1, 2 or 3, both are 0.
- R5: prg_addr[13] equals core_prg_bank[0] when prg_mode is 0, and equals cpu_addr[13] when prg_mode is 1, 2 or 3.
- R6: prg_addr[14] equals cpu_addr[14] when prg_mode is 3, and equals core_prg_bank[1] otherwise. prg_addr[16:15] always equal core_prg_bank[3:2].
- R7: chr_addr[19:18] equals outer_cfg[5:4]. chr_addr[17] equals outer_cfg[3] when outer_cfg[7] is 1, and equals core_chr_bank[7] when outer_cfg[7] is 0. Both hold in either pattern mode.
- R8: When chr_fixed_en is 0, chr_addr[16:10] equals core_chr_bank[6:0] and chr_addr[9:0] equals ppu_addr[9:0]. fixed_chr_bank has no effect on chr_addr in this mode.
- R9: When chr_fixed_en is 1, chr_addr[16:13] equals fixed_chr_bank and chr_addr[12:0] equals ppu_addr[12:0]. core_chr_bank[6:0] has no effect on chr_addr in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 15 | CPU address bits A14..A0 |
| ppu_addr | input | 13 | Picture-bus address bits A12..A0 |
| core_prg_bank | input | 5 | Core program bank outputs A17..A13 |
| core_chr_bank | input | 8 | Core pattern bank outputs A17..A10 |
| outer_cfg | input | 8 | Outer bank byte: bit7 pattern size select, bit6 program size select, bits5..4 shared high bank, bit3 pattern A17, bits2..1 program A19..A18, bit0 program A17 |
| fixed_chr_bank | input | 4 | 8 KiB pattern bank number used in fixed pattern mode |
| prg_mode | input | 2 | 0 banked, 1 and 2 16 KiB fixed window, 3 32 KiB fixed window |
| chr_fixed_en | input | 1 | 1 selects fixed 8 KiB pattern banking |
| core_cpu_a13 | output | 1 | A13 presented to the core |
| core_cpu_a14 | output | 1 | A14 presented to the core |
| prg_addr | output | 22 | Program ROM address A21..A0 |
| chr_addr | output | 20 | Pattern ROM address A19..A0 |

## Verification
The checker re-evaluates every output bit against the requirements whenever any input changes. It covers the pass-through low lines, the outer-bank bits, both size selects, the gating of the core's A13/A14, and the source of each swapped line in every program and pattern mode. What the checker cannot show is that an unused input truly has no effect. The bench shows this by holding every other input and changing fixed_chr_bank in banked pattern mode, or the core's pattern bank in fixed mode, then confirming that chr_addr keeps its value. The bench's vector table also pins exact full-width addresses for mixed mode combinations, and some of those could still be wrong even when each bit rule holds on its own.

// File: rtl/mapcomp_pkg.sv
package mapcomp_pkg;
    parameter int CPU_AW      = 15;
    parameter int PPU_AW      = 13;
    parameter int PAGE_W      = 13;
    parameter int CHR_SLICE_W = 10;
    parameter int INNER_TOP   = 18;
    parameter int PRG_OUT_AW  = 22;
    parameter int CHR_OUT_AW  = 20;
    parameter int OUTER_W     = 8;
    parameter int FIX_CHR_W   = 4;
    parameter int CORE_PRG_W  = INNER_TOP - PAGE_W;
    parameter int CORE_CHR_W  = INNER_TOP - CHR_SLICE_W;

    typedef enum logic [1:0] {
        PM_BANKED   = 2'd0,
        PM_HALF     = 2'd1,
        PM_HALF_ALT = 2'd2,
        PM_FULL     = 2'd3
    } prg_mode_e;

    typedef enum logic {
        CM_BANKED = 1'b0,
        CM_FIXED  = 1'b1
    } chr_mode_e;
endpackage

// File: rtl/mapcomp_prg_path.sv
module mapcomp_prg_path
    import mapcomp_pkg::*;
(
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [CORE_PRG_W-1:0] core_bank,
    input  logic [OUTER_W-1:0]    outer_cfg,
    input  prg_mode_e             mode,
    output logic                  core_a13,
    output logic                  core_a14,
    output logic [PRG_OUT_AW-1:0] addr
);
    localparam int A13 = PAGE_W;
    localparam int A14 = PAGE_W + 1;

    logic sel_a13;
    logic sel_a14;
    logic sel_a17;

    always_comb begin
        sel_a13  = core_bank[0];
        sel_a14  = core_bank[1];
        core_a13 = cpu_addr[A13];
        core_a14 = cpu_addr[A14];
        unique case (mode)
            PM_BANKED: begin
                sel_a13  = core_bank[0];
                sel_a14  = core_bank[1];
                core_a13 = cpu_addr[A13];
                core_a14 = cpu_addr[A14];
            end
            PM_HALF, PM_HALF_ALT: begin
                sel_a13  = cpu_addr[A13];
                sel_a14  = core_bank[1];
                core_a13 = 1'b0;
                core_a14 = 1'b0;
            end
            PM_FULL: begin
                sel_a13  = cpu_addr[A13];
                sel_a14  = cpu_addr[A14];
                core_a13 = 1'b0;
                core_a14 = 1'b0;
            end
            default: begin
                sel_a13  = core_bank[0];
                sel_a14  = core_bank[1];
                core_a13 = cpu_addr[A13];
                core_a14 = cpu_addr[A14];
            end
        endcase
    end

    always_comb begin
        sel_a17 = outer_cfg[6] ? outer_cfg[0] : core_bank[CORE_PRG_W-1];
    end

    always_comb begin
        addr               = '0;
        addr[PAGE_W-1:0]   = cpu_addr[PAGE_W-1:0];
        addr[A13]          = sel_a13;
        addr[A14]          = sel_a14;
        addr[16:15]        = core_bank[3:2];
        addr[17]           = sel_a17;
        addr[19:18]        = outer_cfg[2:1];
        addr[21:20]        = outer_cfg[5:4];
    end
endmodule

// File: rtl/mapcomp_chr_path.sv
module mapcomp_chr_path
    import mapcomp_pkg::*;
(
    input  logic [PPU_AW-1:0]     ppu_addr,
    input  logic [CORE_CHR_W-1:0] core_bank,
    input  logic [OUTER_W-1:0]    outer_cfg,
    input  logic [FIX_CHR_W-1:0]  fixed_bank,
    input  chr_mode_e             mode,
    output logic [CHR_OUT_AW-1:0] addr
);
    localparam int INNER_W = INNER_TOP - 1;

    logic [INNER_W-1:0] inner;
    logic               sel_a17;

    always_comb begin
        unique case (mode)
            CM_FIXED:  inner = {fixed_bank, ppu_addr[PAGE_W-1:0]};
            CM_BANKED: inner = {core_bank[CORE_CHR_W-2:0], ppu_addr[CHR_SLICE_W-1:0]};
            default:   inner = {core_bank[CORE_CHR_W-2:0], ppu_addr[CHR_SLICE_W-1:0]};
        endcase
    end

    always_comb begin
        sel_a17 = outer_cfg[7] ? outer_cfg[3] : core_bank[CORE_CHR_W-1];
    end

    always_comb begin
        addr              = '0;
        addr[INNER_W-1:0] = inner;
        addr[INNER_W]     = sel_a17;
        addr[19:18]       = outer_cfg[5:4];
    end
endmodule

// File: rtl/mapcomp_top.sv
module mapcomp_top
    import mapcomp_pkg::*;
(
    input  logic [14:0] cpu_addr,
    input  logic [12:0] ppu_addr,
    input  logic [4:0]  core_prg_bank,
    input  logic [7:0]  core_chr_bank,
    input  logic [7:0]  outer_cfg,
    input  logic [3:0]  fixed_chr_bank,
    input  logic [1:0]  prg_mode,
    input  logic        chr_fixed_en,
    output logic        core_cpu_a13,
    output logic        core_cpu_a14,
    output logic [21:0] prg_addr,
    output logic [19:0] chr_addr
);
    prg_mode_e pm;
    chr_mode_e cm;

    always_comb begin
        pm = prg_mode_e'(prg_mode);
        cm = chr_mode_e'(chr_fixed_en);
    end

    mapcomp_prg_path u_prg (
        .cpu_addr  (cpu_addr),
        .core_bank (core_prg_bank),
        .outer_cfg (outer_cfg),
        .mode      (pm),
        .core_a13  (core_cpu_a13),
        .core_a14  (core_cpu_a14),
        .addr      (prg_addr)
    );

    mapcomp_chr_path u_chr (
        .ppu_addr   (ppu_addr),
        .core_bank  (core_chr_bank),
        .outer_cfg  (outer_cfg),
        .fixed_bank (fixed_chr_bank),
        .mode       (cm),
        .addr       (chr_addr)
    );
endmodule

// File: rtl/mapcomp_chk.sv
module mapcomp_chk (
    input logic [14:0] cpu_addr,
    input logic [12:0] ppu_addr,
    input logic [4:0]  core_prg_bank,
    input logic [7:0]  core_chr_bank,
    input logic [7:0]  outer_cfg,
    input logic [3:0]  fixed_chr_bank,
    input logic [1:0]  prg_mode,
    input logic        chr_fixed_en,
    input logic        core_cpu_a13,
    input logic        core_cpu_a14,
    input logic [21:0] prg_addr,
    input logic [19:0] chr_addr
);
    always_comb begin
        // R1
        prg_low_chk: assert (prg_addr[12:0] == cpu_addr[12:0]);
        // R2
        prg_outer_chk: assert (prg_addr[21:18] == {outer_cfg[5:4], outer_cfg[2:1]});
        // R3
        prg_a17_chk: assert (outer_cfg[6] ? (prg_addr[17] == outer_cfg[0])
                                          : (prg_addr[17] == core_prg_bank[4]));
        // R4
        core_gate_chk: assert ((prg_mode == 2'd0)
                               ? ({core_cpu_a14, core_cpu_a13} == cpu_addr[14:13])
                               : ({core_cpu_a14, core_cpu_a13} == 2'b00));
        // R5
        prg_a13_chk: assert ((prg_mode == 2'd0) ? (prg_addr[13] == core_prg_bank[0])
                                                : (prg_addr[13] == cpu_addr[13]));
        // R6
        prg_a14_chk: assert (((prg_mode == 2'd3) ? (prg_addr[14] == cpu_addr[14])
                                                 : (prg_addr[14] == core_prg_bank[1]))
                             && (prg_addr[16:15] == core_prg_bank[3:2]));
        // R7
        chr_outer_chk: assert ((chr_addr[19:18] == outer_cfg[5:4])
                               && (outer_cfg[7] ? (chr_addr[17] == outer_cfg[3])
                                                : (chr_addr[17] == core_chr_bank[7])));
        // R8
        chr_banked_chk: assert (chr_fixed_en
                                || (chr_addr[16:0] == {core_chr_bank[6:0], ppu_addr[9:0]}));
        // R9
        chr_fixed_chk: assert (!chr_fixed_en
                               || (chr_addr[16:0] == {fixed_chr_bank, ppu_addr}));
    end
endmodule

bind mapcomp_top mapcomp_chk u_chk (
    .cpu_addr       (cpu_addr),
    .ppu_addr       (ppu_addr),
    .core_prg_bank  (core_prg_bank),
    .core_chr_bank  (core_chr_bank),
    .outer_cfg      (outer_cfg),
    .fixed_chr_bank (fixed_chr_bank),
    .prg_mode       (prg_mode),
    .chr_fixed_en   (chr_fixed_en),
    .core_cpu_a13   (core_cpu_a13),
    .core_cpu_a14   (core_cpu_a14),
    .prg_addr       (prg_addr),
    .chr_addr       (chr_addr)
);

// File: tb/mapcomp_top_test.sv
module mapcomp_top_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 7;

    typedef struct packed {
        logic [14:0] cpu;
        logic [12:0] ppu;
        logic [4:0]  cprg;
        logic [7:0]  cchr;
        logic [7:0]  outer;
        logic [3:0]  fix;
        logic [1:0]  pm;
        logic        cm;
        logic [21:0] eprg;
        logic [19:0] echr;
        logic        ea13;
        logic        ea14;
    } vec_t;

    // Expected values worked out by hand from R1..R9.
    localparam vec_t TBL [NVEC] = '{
        '{15'h0000, 13'h0000, 5'b00000, 8'h00, 8'h00, 4'h0, 2'd0, 1'b0, 22'h000000, 20'h00000, 1'b0, 1'b0},
        '{15'h6ABC, 13'h1234, 5'b10110, 8'hA5, 8'h00, 4'hF, 2'd0, 1'b0, 22'h02CABC, 20'h29634, 1'b1, 1'b1},
        '{15'h6ABC, 13'h1234, 5'b10110, 8'hA5, 8'hFF, 4'h9, 2'd3, 1'b1, 22'h3EEABC, 20'hF3234, 1'b0, 1'b0},
        '{15'h6ABC, 13'h1FFF, 5'b01001, 8'h5A, 8'h36, 4'h3, 2'd1, 1'b0, 22'h3D2ABC, 20'hD6BFF, 1'b0, 1'b0},
        '{15'h1555, 13'h0000, 5'b11111, 8'h00, 8'hC8, 4'h0, 2'd2, 1'b1, 22'h01D555, 20'h20000, 1'b0, 1'b0},
        '{15'h2000, 13'h0000, 5'b00000, 8'hFF, 8'h40, 4'hF, 2'd0, 1'b0, 22'h000000, 20'h3FC00, 1'b1, 1'b0},
        '{15'h4000, 13'h0001, 5'b00000, 8'hFF, 8'h00, 4'hA, 2'd3, 1'b1, 22'h004000, 20'h34001, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [12:0] ppu_addr = '0;
    logic [4:0]  core_prg_bank = '0;
    logic [7:0]  core_chr_bank = '0;
    logic [7:0]  outer_cfg = '0;
    logic [3:0]  fixed_chr_bank = '0;
    logic [1:0]  prg_mode = '0;
    logic        chr_fixed_en = 1'b0;
    logic        core_cpu_a13;
    logic        core_cpu_a14;
    logic [21:0] prg_addr;
    logic [19:0] chr_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mapcomp_top uut (
        .cpu_addr       (cpu_addr),
        .ppu_addr       (ppu_addr),
        .core_prg_bank  (core_prg_bank),
        .core_chr_bank  (core_chr_bank),
        .outer_cfg      (outer_cfg),
        .fixed_chr_bank (fixed_chr_bank),
        .prg_mode       (prg_mode),
        .chr_fixed_en   (chr_fixed_en),
        .core_cpu_a13   (core_cpu_a13),
        .core_cpu_a14   (core_cpu_a14),
        .prg_addr       (prg_addr),
        .chr_addr       (chr_addr)
    );

    task automatic apply(input vec_t v);
        @(posedge clk);
        cpu_addr       = v.cpu;
        ppu_addr       = v.ppu;
        core_prg_bank  = v.cprg;
        core_chr_bank  = v.cchr;
        outer_cfg      = v.outer;
        fixed_chr_bank = v.fix;
        prg_mode       = v.pm;
        chr_fixed_en   = v.cm;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        check({tag, " prg_addr (R1 R2 R3 R5 R6)"}, 64'(prg_addr), 64'(v.eprg));
        check({tag, " chr_addr (R7 R8 R9)"},       64'(chr_addr), 64'(v.echr));
        check({tag, " core A14/A13 (R4)"},
              64'({core_cpu_a14, core_cpu_a13}), 64'({v.ea14, v.ea13}));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        // Idle state: all-zero inputs give all-zero outputs (R1 R4 R8).
        apply(TBL[0]);
        check("idle prg_addr R1", 64'(prg_addr), 64'h0);
        check("idle chr_addr R8", 64'(chr_addr), 64'h0);
        check("idle core lines R4", 64'({core_cpu_a14, core_cpu_a13}), 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i]);
            check_vec(TBL[i], $sformatf("vec%0d", i));
        end

        // R8: fixed_chr_bank has no effect in banked pattern mode.
        v = TBL[1];
        v.fix = 4'h0;
        apply(v);
        check("R8 fixed bank ignored", 64'(chr_addr), 64'h29634);

        // R9: core pattern bank A16..A10 has no effect in fixed pattern mode.
        v = TBL[2];
        v.cchr = 8'h00;
        apply(v);
        check("R9 core chr bank ignored", 64'(chr_addr), 64'hF3234);

        // R6: mode 2 behaves like mode 1; A14 from core, not CPU.
        v = TBL[3];
        v.pm = 2'd2;
        apply(v);
        check("R6 mode2 matches mode1", 64'(prg_addr), 64'h3D2ABC);

        // R3: flipping the size select takes A17 from outer bit 0.
        v = TBL[1];
        v.outer = 8'h40;
        apply(v);
        check("R3 small inner prg bank", 64'(prg_addr), 64'h00CABC);

        // R7: pattern size select takes A17 from outer bit 3.
        v = TBL[1];
        v.outer = 8'h80;
        apply(v);
        check("R7 small inner chr bank", 64'(chr_addr), 64'h09634);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule